// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block models a small serial memory that answers on a three-wire bus: a chip select, a serial clock and a data input, plus one data output. It stores 64 words of 16 bits in flip-flops. The bus master raises chip select and sends a start bit, a 2-bit opcode and a 6-bit word address, all most significant bit first. A read then streams words back. A write or an erase is armed, and it starts when chip select falls. Enable and disable commands control a write-protect latch.

The serial clock and the bus inputs are sampled by the block's system clock. A rising serial-clock edge is seen as a low-to-high change between two system-clock samples. A write or an erase runs a simulated program cycle that lasts a set number of system clocks. When the master raises chip select again, the data output shows the cycle's status: low while the cycle runs and high once it has finished.

Top module: `mw_serial_eeprom`

## Requirements
- R1: After reset, writes are disabled, every word reads as 0x0000, and the data output is low with chip select high.
- R2: Bits are taken from the data input on each rising serial-clock edge while chip select is high. Zeros before the first 1 are skipped. That 1 is the start bit. The next 2 bits are the opcode and the next 6 bits are the address, both most significant bit first.
- R3: Opcode 2'b10 is a read. After the rising edge that carries the last address bit, the data output shows a dummy 0. Each later rising edge then presents the next bit of the word, from D15 down to D0.
- R4: If the serial clock keeps running during a read, the word at the next address follows with no dummy bit between words, and address 63 is followed by address 0.
- R5: Opcode 2'b01 is a write and takes 16 data bits, most significant bit first. Opcode 2'b11 is an erase and sets the word to 0xFFFF. When accepted, either one replaces the whole word, and the command takes effect when chip select falls after a complete command.
- R6: Opcode 2'b00 with address bits [5:4] = 2'b11 enables writes. With address bits [5:4] = 2'b00 it disables them. The enable stays in force over any number of writes until a disable arrives or reset.
- R7: While writes are disabled, write and erase commands leave memory unchanged. Reads work in either state.
- R8: An accepted write or erase holds busy for PROG_CYCLES system clocks. With chip select high and no new start bit, the data output is low while busy and high when done.
- R9: If chip select falls before a command is complete, the command has no effect.
- R10: While a program cycle is busy, start bits are ignored, so no command can be decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock, sampled by clk |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out / ready-busy status |

## Verification
On every cycle, the assertions check the following. A program request never starts while a cycle is busy and is always followed by busy. A write-enable gate stands before every memory update. An aborted frame never produces a request. A busy cycle holds the decoder in its idle state. Each read begins with a dummy zero, and the addressed word holds the data written after each store. The bench scenarios are the only way to show the bit order of a serial read, the address wrap during streaming, leading-zero skipping, the status polarity seen on a fresh chip select, and that the enable latch persists or is cleared by reset.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    localparam int MW_ADDR_W = 6;
    localparam int MW_DATA_W = 16;
    localparam int MW_DEPTH  = 1 << MW_ADDR_W;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_ADR,
        FS_RDAT,
        FS_WDAT,
        FS_ARMED
    } frame_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opcode_e;

    localparam logic [1:0] EXT_ENABLE  = 2'b11;
    localparam logic [1:0] EXT_DISABLE = 2'b00;

    typedef struct packed {
        logic                 valid;
        logic [MW_ADDR_W-1:0] addr;
        logic [MW_DATA_W-1:0] data;
    } prog_req_t;

    function automatic logic [1:0] ext_code(input logic [MW_ADDR_W-1:0] a);
        return a[MW_ADDR_W-1 -: 2];
    endfunction

endpackage

// File: rtl/mw_word_store.sv
module mw_word_store
    import mw_eeprom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [MW_ADDR_W-1:0] waddr_i,
    input  logic [MW_DATA_W-1:0] wdata_i,
    input  logic [MW_ADDR_W-1:0] raddr_i,
    output logic [MW_DATA_W-1:0] rdata_o
);

    logic [MW_DATA_W-1:0] words [MW_DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < MW_DEPTH; i++) begin
            if (rst) begin
                words[i] <= '0;
            end else if (we_i && waddr_i == MW_ADDR_W'(i)) begin
                words[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = words[raddr_i];

    // R5: a store request leaves the addressed word holding its data
    p_store_lands_r5: assert property (@(posedge clk) disable iff (rst)
        we_i |=> words[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer
    import mw_eeprom_pkg::*;
#(
    parameter int PROG_CYCLES = 200
) (
    input  logic                 clk,
    input  logic                 rst,
    input  prog_req_t            req_i,
    output logic                 busy_o,
    output logic                 we_o,
    output logic [MW_ADDR_W-1:0] waddr_o,
    output logic [MW_DATA_W-1:0] wdata_o
);

    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            waddr_o  <= '0;
            wdata_o  <= '0;
        end else if (req_i.valid && remain_q == '0) begin
            remain_q <= LOAD;
            waddr_o  <= req_i.addr;
            wdata_o  <= req_i.data;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy_o = (remain_q != '0);
    assign we_o   = (remain_q == CW'(1));

    // R10: requests only reach an idle timer
    p_req_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        req_i.valid |-> !busy_o);

    // R8: an accepted request makes the block busy on the next cycle
    p_req_starts_busy_r8: assert property (@(posedge clk) disable iff (rst)
        req_i.valid |=> busy_o);

    // R8: the commit closes the program cycle
    p_commit_ends_busy_r8: assert property (@(posedge clk) disable iff (rst)
        we_o |=> !busy_o);

endmodule

// File: rtl/mw_frame_ctrl.sv
module mw_frame_ctrl
    import mw_eeprom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_i,
    input  logic                 sk_i,
    input  logic                 di_i,
    input  logic                 busy_i,
    input  logic [MW_DATA_W-1:0] rd_word_i,
    output logic [MW_ADDR_W-1:0] rd_addr_o,
    output prog_req_t            req_o,
    output logic                 do_o
);

    localparam int CNT_W = $clog2(MW_DATA_W);
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(1);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(MW_ADDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(MW_DATA_W - 1);

    frame_state_e         state_q;
    opcode_e              op_q;
    logic                 sk_q, cs_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [MW_ADDR_W-1:0] addr_q;
    logic [MW_DATA_W-1:0] wdata_q;
    logic                 dout_q;
    logic                 wen_q;
    logic                 stat_q;
    logic                 rise;
    logic [CNT_W-1:0]     bit_idx;
    logic [MW_ADDR_W-1:0] addr_nx;

    assign rise    = sk_i & ~sk_q;
    assign bit_idx = DAT_LAST - cnt_q;
    assign addr_nx = {addr_q[MW_ADDR_W-2:0], di_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            op_q    <= OP_EXT;
            sk_q    <= 1'b0;
            cs_q    <= 1'b0;
            cnt_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            dout_q  <= 1'b0;
            wen_q   <= 1'b0;
            stat_q  <= 1'b0;
            req_o   <= '0;
        end else begin
            sk_q        <= sk_i;
            cs_q        <= cs_i;
            req_o.valid <= 1'b0;
            if (!cs_i) begin
                state_q <= FS_IDLE;
                if (cs_q && state_q == FS_ARMED) begin
                    unique case (op_q)
                        OP_WRITE: if (wen_q) begin
                            req_o  <= '{valid: 1'b1, addr: addr_q, data: wdata_q};
                            stat_q <= 1'b1;
                        end
                        OP_ERASE: if (wen_q) begin
                            req_o  <= '{valid: 1'b1, addr: addr_q, data: '1};
                            stat_q <= 1'b1;
                        end
                        OP_EXT: begin
                            if (ext_code(addr_q) == EXT_ENABLE) begin
                                wen_q <= 1'b1;
                            end else if (ext_code(addr_q) == EXT_DISABLE) begin
                                wen_q <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (rise) begin
                unique case (state_q)
                    FS_IDLE: if (di_i && !busy_i) begin
                        state_q <= FS_OPC;
                        cnt_q   <= '0;
                        stat_q  <= 1'b0;
                    end
                    FS_OPC: begin
                        op_q <= opcode_e'({op_q[0], di_i});
                        if (cnt_q == OPC_LAST) begin
                            state_q <= FS_ADR;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FS_ADR: begin
                        addr_q <= addr_nx;
                        if (cnt_q == ADR_LAST) begin
                            cnt_q <= '0;
                            if (op_q == OP_READ) begin
                                state_q <= FS_RDAT;
                                dout_q  <= 1'b0;
                            end else if (op_q == OP_WRITE) begin
                                state_q <= FS_WDAT;
                            end else begin
                                state_q <= FS_ARMED;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FS_RDAT: begin
                        dout_q <= rd_word_i[bit_idx];
                        if (cnt_q == DAT_LAST) begin
                            cnt_q  <= '0;
                            addr_q <= addr_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FS_WDAT: begin
                        wdata_q <= {wdata_q[MW_DATA_W-2:0], di_i};
                        if (cnt_q == DAT_LAST) begin
                            state_q <= FS_ARMED;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr_o = addr_q;

    always_comb begin
        do_o = 1'b0;
        if (cs_i) begin
            if (state_q == FS_RDAT) begin
                do_o = dout_q;
            end else if (state_q == FS_IDLE && stat_q) begin
                do_o = ~busy_i;
            end
        end
    end

    // R7: a program request is only issued while writes are enabled
    p_req_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        req_o.valid |-> wen_q);

    // R3: the first read output after the address is the dummy zero
    p_dummy_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_RDAT && $past(state_q) == FS_ADR) |-> !dout_q);

    // R9: dropping chip select outside the armed state issues nothing
    p_abort_silent_r9: assert property (@(posedge clk) disable iff (rst)
        (cs_q && !cs_i && state_q != FS_ARMED) |=> !req_o.valid);

    // R10: the decoder stays idle while a program cycle runs
    p_busy_holds_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_i && state_q == FS_IDLE) |=> state_q == FS_IDLE);

endmodule

// File: rtl/mw_serial_eeprom.sv
module mw_serial_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o
);

    prog_req_t            req;
    logic                 busy;
    logic                 we;
    logic [MW_ADDR_W-1:0] waddr;
    logic [MW_DATA_W-1:0] wdata;
    logic [MW_ADDR_W-1:0] raddr;
    logic [MW_DATA_W-1:0] rdata;

    mw_frame_ctrl u_frame (
        .clk       (clk),
        .rst       (rst),
        .cs_i      (cs_i),
        .sk_i      (sk_i),
        .di_i      (di_i),
        .busy_i    (busy),
        .rd_word_i (rdata),
        .rd_addr_o (raddr),
        .req_o     (req),
        .do_o      (do_o)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .busy_o  (busy),
        .we_o    (we),
        .waddr_o (waddr),
        .wdata_o (wdata)
    );

    mw_word_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

endmodule

// File: tb/mw_serial_eeprom_tb.sv
module mw_serial_eeprom_tb_top;

    localparam int PC = 40;
    localparam int NV = 6;
    localparam logic [21:0] VEC [NV] = '{
        {6'd0,  16'hA5C3},
        {6'd62, 16'h1234},
        {6'd63, 16'hFFFE},
        {6'd1,  16'h8001},
        {6'd31, 16'h0F0F},
        {6'd5,  16'h7FFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_w;
    int   checks = 0, failures = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    mw_serial_eeprom #(.PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di), .do_o(do_w)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic s);
        di = b; sk = 1'b1;
        @(negedge clk);
        s = do_w;
        sk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [5:0] a,
                            input int lead, output logic last);
        logic s;
        cs = 1'b1;
        @(negedge clk);
        for (int i = 0; i < lead; i++) send_bit(1'b0, s);
        send_bit(1'b1, s);
        for (int i = 1; i >= 0; i--) send_bit(op[i], s);
        for (int i = 5; i >= 0; i--) send_bit(a[i], s);
        last = s;
    endtask

    task automatic end_frame();
        cs = 1'b0; di = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic get_word(output logic [15:0] w);
        logic s;
        for (int i = 15; i >= 0; i--) begin
            send_bit(1'b0, s);
            w[i] = s;
        end
    endtask

    task automatic read_check(input logic [5:0] a, input logic [15:0] exp,
                              input int lead, input string req);
        logic d;
        logic [15:0] w;
        send_cmd(2'b10, a, lead, d);
        check(d == 1'b0, "R3 dummy bit", 32'(d), 32'h0);
        get_word(w);
        check(w == exp, req, 32'(w), 32'(exp));
        end_frame();
    endtask

    task automatic write_word(input logic [5:0] a, input logic [15:0] v);
        logic s;
        send_cmd(2'b01, a, 0, s);
        for (int i = 15; i >= 0; i--) send_bit(v[i], s);
        end_frame();
    endtask

    task automatic ext_cmd(input logic [1:0] code);
        logic s;
        send_cmd(2'b00, {code, 4'b0000}, 0, s);
        end_frame();
    endtask

    task automatic wait_ready(output int lows);
        lows = 0;
        cs = 1'b1;
        for (int g = 0; g < 1000; g++) begin
            @(negedge clk);
            if (do_w) break;
            lows++;
        end
        cs = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lows;
        logic s;
        logic [15:0] w;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        cs = 1'b1;
        @(negedge clk);
        check(do_w == 1'b0, "R1 do low after reset", 32'(do_w), 32'h0);
        cs = 1'b0;
        @(negedge clk);
        read_check(6'd9, 16'h0000, 0, "R1 word zero after reset");

        // R7: disabled write and erase ignored
        write_word(6'd5, 16'h1234);
        read_check(6'd5, 16'h0000, 0, "R7 write ignored when disabled");
        send_cmd(2'b11, 6'd6, 0, s);
        end_frame();
        read_check(6'd6, 16'h0000, 0, "R7 erase ignored when disabled");

        // R6: enable, then a table of writes with one enable
        ext_cmd(2'b11);
        for (int i = 0; i < NV; i++) begin
            write_word(VEC[i][21:16], VEC[i][15:0]);
            wait_ready(lows);
            check(lows >= PC - 2 && lows <= PC, "R8 busy length",
                  32'(lows), 32'(PC - 1));
            read_check(VEC[i][21:16], VEC[i][15:0], i % 2 * 3,
                       "R5 R6 R2 write then read back");
        end

        // R4: streaming read wraps 62 -> 63 -> 0
        send_cmd(2'b10, 6'd62, 0, s);
        get_word(w);
        check(w == 16'h1234, "R4 stream word 62", 32'(w), 32'h1234);
        get_word(w);
        check(w == 16'hFFFE, "R4 stream word 63", 32'(w), 32'hFFFE);
        get_word(w);
        check(w == 16'hA5C3, "R4 stream wrap to 0", 32'(w), 32'hA5C3);
        end_frame();

        // R5: erase sets all ones
        send_cmd(2'b11, 6'd1, 0, s);
        end_frame();
        wait_ready(lows);
        read_check(6'd1, 16'hFFFF, 0, "R5 erase word");

        // R9: abort mid write
        send_cmd(2'b01, 6'd31, 0, s);
        for (int i = 0; i < 10; i++) send_bit(1'b1, s);
        end_frame();
        cs = 1'b1;
        repeat (PC + 4) @(negedge clk);
        check(do_w == 1'b0, "R9 no program after abort", 32'(do_w), 32'h0);
        cs = 1'b0;
        @(negedge clk);
        read_check(6'd31, 16'h0F0F, 0, "R9 word unchanged after abort");

        // R10: a disable sent during busy is ignored
        write_word(6'd2, 16'h5555);
        cs = 1'b1;
        send_bit(1'b1, s);
        for (int i = 0; i < 8; i++) send_bit(1'b0, s);
        check(do_w == 1'b0, "R10 still busy after probe", 32'(do_w), 32'h0);
        wait_ready(lows);
        write_word(6'd3, 16'hAAAA);
        wait_ready(lows);
        read_check(6'd3, 16'hAAAA, 0, "R10 command during busy ignored");
        read_check(6'd2, 16'h5555, 0, "R10 first write kept");

        // R6: disable stops writes
        ext_cmd(2'b00);
        write_word(6'd3, 16'h1111);
        read_check(6'd3, 16'hAAAA, 0, "R6 disable blocks write");

        // R1: reset clears contents and the enable
        ext_cmd(2'b11);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        read_check(6'd62, 16'h0000, 0, "R1 contents cleared by reset");
        write_word(6'd4, 16'hBEEF);
        read_check(6'd4, 16'h0000, 0, "R1 reset leaves writes disabled");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule